// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Load Forwarding

This block sits between one hardware thread's load/store port and the shared memory port. Stores from the thread go into a small in-order queue and are written to memory later, oldest first, one per cycle, through a valid/ready handshake toward the memory arbiter. A load first looks for queued stores to the same address. If it finds any, it returns the value of the youngest one and does not touch memory. If it finds none, it reads memory combinationally.

A blocking input shows that another thread holds the global memory lock. While that input is high, the block issues no memory read and no drain write. Stores are still queued, and loads that hit the queue still complete. A fence request completes once the queue is empty, and draining goes on while the fence waits. A system builds one instance per hardware thread. Together the instances give total-store-order behaviour: a thread can see its own stores early, and all threads see stores reach memory in program order.

Top module: `tso_wbuf`

## Requirements
- R1: After reset the queue is empty: `mem_wr_valid` is 0, `st_ready` is 1, and a fence request completes in the same cycle.
- R2: A store is accepted on a rising edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while DEPTH (default 4) entries are held, and a store presented then is dropped and never written to memory.
- R3: Queued stores reach memory strictly oldest first, with the address and data they were stored with. One entry leaves per cycle in which `mem_wr_valid` and `mem_wr_ready` are both 1.
- R4: While `mem_wr_valid` is 1 and `mem_wr_ready` is 0, `mem_wr_addr` and `mem_wr_data` hold their values into the next cycle.
- R5: A load whose address matches one or more queued entries completes in the same cycle. It sets `ld_ready=1` and `ld_fwd=1`, returns the youngest matching entry's data, and keeps `mem_rd_en` at 0. This holds even while `lock_blocked` is 1.
- R6: A load that matches no queued entry, with `lock_blocked` at 0, drives `mem_rd_en=1` with `mem_rd_addr` set to the load address. It returns `mem_rd_data` in the same cycle with `ld_ready=1` and `ld_fwd=0`.
- R7: While `lock_blocked` is 1, `mem_wr_valid` and `mem_rd_en` are 0, and a load that matches no entry sees `ld_ready=0`. When `lock_blocked` returns to 0, draining resumes.
- R8: `fence_done` is 1 exactly in the cycles where `fence_req` is 1 and the queue is empty. The queue keeps draining while a fence waits.
- R9: Take two instances sharing memory, with locations X and Y both at 0. Thread A stores X=1 then loads Y, and thread B stores Y=1 then loads X. Without a fence, both loads can return 0. With a completed fence between each store and its load, both loads return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_blocked | input | 1 | Another thread holds the global lock |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Queue can accept a store |
| ld_valid | input | 1 | Load request |
| ld_addr | input | ADDR_W | Load address |
| ld_ready | output | 1 | Load completes this cycle |
| ld_data | output | DATA_W | Load result |
| ld_fwd | output | 1 | Load result came from the queue |
| fence_req | input | 1 | Fence request |
| fence_done | output | 1 | Fence completes this cycle |
| mem_wr_valid | output | 1 | Drain write request |
| mem_wr_ready | input | 1 | Memory accepts drain write |
| mem_wr_addr | output | ADDR_W | Drain write address (oldest entry) |
| mem_wr_data | output | DATA_W | Drain write data (oldest entry) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Memory read data, same cycle |

## Verification
A broken queue shows up at the ports in one of two ways. A forwarding load returns an older or wrong value in the same cycle it is issued. Or the drain sequence shows the wrong order, a missing store, or a store that should have been dropped. An occupancy count out of step with the entry valid bits shows up at once as a fence that completes early or hangs. A gating error on the lock input shows up within one cycle as a memory read or drain write while blocked. The paired-instance test with and without fences shows whether the visibility ordering as a whole holds together.

// File: rtl/tso_wbuf_pkg.sv
// Shared types for the write buffer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tso_wbuf_pkg;
    // Where a load result comes from.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BUF  = 2'd1,
        SRC_MEM  = 2'd2
    } ld_src_e;
endpackage

// File: rtl/tso_wbuf_fifo.sv
// Circular in-order queue of (address, data) entries with a valid bit per entry.
// Assumes: push is asserted only when not full; pop only when not empty.
module tso_wbuf_fifo #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic                          full,
    output logic                          empty,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic [DEPTH-1:0]              ent_vld,
    output logic [$clog2(DEPTH)-1:0]      rd_ptr,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [DATA_W-1:0]             head_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    // Entry storage and per-entry valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else begin
            if (push) begin
                ent_addr[wr_ptr] <= push_addr;
                ent_data[wr_ptr] <= push_data;
                ent_vld[wr_ptr]  <= 1'b1;
            end
            if (pop) begin
                ent_vld[rd_ptr] <= 1'b0;
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Status and oldest-entry view.
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        head_addr = ent_addr[rd_ptr];
        head_data = ent_data[rd_ptr];
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(DEPTH)));

    assert_vld_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_vld) == int'(count));
endmodule

// File: rtl/tso_wbuf_match.sv
// Address comparators per entry plus a priority pick of the youngest valid match.
// Assumes: valid entries are contiguous starting at rd_ptr (oldest).
module tso_wbuf_match #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    input  logic [DEPTH-1:0]              ent_vld,
    input  logic [$clog2(DEPTH)-1:0]      rd_ptr,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);
    logic [DEPTH-1:0] eq;

    // One comparator per physical entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = ent_vld[g] && (ent_addr[g] == ld_addr);
    end

    // Walk from oldest to youngest; the last match seen wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int idx;
            idx = (int'(rd_ptr) + i) % DEPTH;
            if (eq[idx]) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
    end
endmodule

// File: rtl/tso_wbuf.sv
// Per-thread store buffer: queues stores, forwards to loads, drains in order,
// and completes fences on empty. lock_blocked gates memory reads and drains.
// Assumes: memory read data returns combinationally in the cycle of mem_rd_en.
module tso_wbuf
    import tso_wbuf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_blocked,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_fwd,
    input  logic              fence_req,
    output logic              fence_done,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data
);
    localparam int PW = $clog2(DEPTH);

    logic                         full, empty, push, pop, hit;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    logic [DEPTH-1:0]             ent_vld;
    logic [PW-1:0]                rd_ptr;
    logic [DATA_W-1:0]            hit_data;
    ld_src_e                      src;

    tso_wbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .pop(pop),
        .full(full), .empty(empty),
        .ent_addr(ent_addr), .ent_data(ent_data), .ent_vld(ent_vld), .rd_ptr(rd_ptr),
        .head_addr(mem_wr_addr), .head_data(mem_wr_data)
    );

    tso_wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .ld_addr(ld_addr), .ent_addr(ent_addr), .ent_data(ent_data),
        .ent_vld(ent_vld), .rd_ptr(rd_ptr), .hit(hit), .hit_data(hit_data)
    );

    // Store acceptance and drain handshake.
    always_comb begin
        st_ready     = !full;
        push         = st_valid && !full;
        mem_wr_valid = !empty && !lock_blocked;
        pop          = mem_wr_valid && mem_wr_ready;
    end

    // Load source selection: queue hit first, memory only when unblocked.
    always_comb begin
        if (!ld_valid)         src = SRC_NONE;
        else if (hit)          src = SRC_BUF;
        else if (!lock_blocked) src = SRC_MEM;
        else                   src = SRC_NONE;
        mem_rd_en   = (src == SRC_MEM);
        mem_rd_addr = ld_addr;
        ld_ready    = (src != SRC_NONE);
        ld_fwd      = (src == SRC_BUF);
        ld_data     = (src == SRC_BUF) ? hit_data : mem_rd_data;
    end

    // Fence completes only on an empty queue.
    always_comb fence_done = fence_req && empty;

    assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_blocked |-> (!mem_wr_valid && !mem_rd_en));

    assert_hit_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && hit) |-> (!mem_rd_en && ld_ready));

    assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> ($stable(mem_wr_addr) && $stable(mem_wr_data)));

    assert_fence_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !mem_wr_valid);
endmodule

// File: tb/tso_wbuf_test.sv
// Bench: table of store/load vectors, then directed tests for reset,
// backpressure, lock blocking, drain order, handshake hold and fences.
module tso_wbuf_test;
    typedef struct packed {
        logic        is_load;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        fwd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h10, 16'h00A1, 1'b0},
        '{1'b0, 8'h20, 16'h00B2, 1'b0},
        '{1'b0, 8'h10, 16'h00A3, 1'b0},
        '{1'b1, 8'h10, 16'h00A3, 1'b1},
        '{1'b1, 8'h20, 16'h00B2, 1'b1},
        '{1'b1, 8'h30, 16'h0090, 1'b0},
        '{1'b0, 8'h30, 16'h00C4, 1'b0},
        '{1'b1, 8'h30, 16'h00C4, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, lock = 1'b0, mem_ready = 1'b0;
    always #10 clk = ~clk;

    logic        u_st_valid = 0, u_st_ready, u_ld_valid = 0, u_ld_ready, u_fwd;
    logic [7:0]  u_st_addr = 0, u_ld_addr = 0, u_wr_addr, u_rd_addr;
    logic [15:0] u_st_data = 0, u_ld_data, u_wr_data, u_rd_data;
    logic        u_fence = 0, u_fdone, u_wr_valid, u_wr_ready, u_rd_en;
    logic        p_st_valid = 0, p_st_ready, p_ld_valid = 0, p_ld_ready, p_fwd;
    logic [7:0]  p_st_addr = 0, p_ld_addr = 0, p_wr_addr, p_rd_addr;
    logic [15:0] p_st_data = 0, p_ld_data, p_wr_data, p_rd_data;
    logic        p_fence = 0, p_fdone, p_wr_valid, p_wr_ready, p_rd_en;

    logic [15:0] mem [256];
    logic [7:0]  log_a [8];
    logic [15:0] log_d [8];
    int          log_n = 0;
    int          checks = 0, errors = 0, cyc = 0;

    assign u_wr_ready = mem_ready;
    assign p_wr_ready = mem_ready && !u_wr_valid;
    assign u_rd_data  = mem[u_rd_addr];
    assign p_rd_data  = mem[p_rd_addr];

    tso_wbuf uut (
        .clk(clk), .rst_n(rst_n), .lock_blocked(lock),
        .st_valid(u_st_valid), .st_addr(u_st_addr), .st_data(u_st_data), .st_ready(u_st_ready),
        .ld_valid(u_ld_valid), .ld_addr(u_ld_addr), .ld_ready(u_ld_ready), .ld_data(u_ld_data),
        .ld_fwd(u_fwd), .fence_req(u_fence), .fence_done(u_fdone),
        .mem_wr_valid(u_wr_valid), .mem_wr_ready(u_wr_ready), .mem_wr_addr(u_wr_addr),
        .mem_wr_data(u_wr_data), .mem_rd_en(u_rd_en), .mem_rd_addr(u_rd_addr), .mem_rd_data(u_rd_data)
    );

    tso_wbuf peer (
        .clk(clk), .rst_n(rst_n), .lock_blocked(1'b0),
        .st_valid(p_st_valid), .st_addr(p_st_addr), .st_data(p_st_data), .st_ready(p_st_ready),
        .ld_valid(p_ld_valid), .ld_addr(p_ld_addr), .ld_ready(p_ld_ready), .ld_data(p_ld_data),
        .ld_fwd(p_fwd), .fence_req(p_fence), .fence_done(p_fdone),
        .mem_wr_valid(p_wr_valid), .mem_wr_ready(p_wr_ready), .mem_wr_addr(p_wr_addr),
        .mem_wr_data(p_wr_data), .mem_rd_en(p_rd_en), .mem_rd_addr(p_rd_addr), .mem_rd_data(p_rd_data)
    );

    // Shared memory model and drain log of the device under test.
    always @(posedge clk) begin
        if (u_wr_valid && u_wr_ready) begin
            mem[u_wr_addr] <= u_wr_data;
            if (log_n < 8) begin
                log_a[log_n] <= u_wr_addr;
                log_d[log_n] <= u_wr_data;
            end
            log_n <= log_n + 1;
        end
        if (p_wr_valid && p_wr_ready) mem[p_wr_addr] <= p_wr_data;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic u_store(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        u_st_valid = 1; u_st_addr = a; u_st_data = d;
        @(negedge clk);
        u_st_valid = 0;
    endtask

    task automatic u_load(input logic [7:0] a);
        @(negedge clk);
        u_ld_valid = 1; u_ld_addr = a;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        u_fence = 1; #1;
        chk("R1 wr_valid after reset", u_wr_valid, 0);
        chk("R1 st_ready after reset", u_st_ready, 1);
        chk("R1 R8 fence on empty same cycle", u_fdone, 1);
        @(negedge clk); u_fence = 0;

        // Table walk with drain held off: R2 R5 R6
        for (int v = 0; v < NV; v++) begin
            if (!VECS[v].is_load) begin
                u_store(VECS[v].addr, VECS[v].data);
            end else begin
                u_load(VECS[v].addr);
                chk($sformatf("R5 R6 vec%0d ready", v), u_ld_ready, 1);
                chk($sformatf("R5 R6 vec%0d data", v), u_ld_data, VECS[v].data);
                chk($sformatf("R5 R6 vec%0d fwd", v), u_fwd, VECS[v].fwd);
                chk($sformatf("R5 R6 vec%0d rd_en", v), u_rd_en, !VECS[v].fwd);
                @(negedge clk); u_ld_valid = 0;
            end
        end

        // R2: full queue backpressures and drops the store
        #1 chk("R2 st_ready when full", u_st_ready, 0);
        u_store(8'h50, 16'h0DEAD);
        // R8: fence waits while entries remain
        u_fence = 1; #1;
        chk("R8 fence held while non-empty", u_fdone, 0);

        // R7: lock blocks drain and memory reads, hits still complete
        lock = 1; mem_ready = 1; #1;
        chk("R7 no drain while blocked", u_wr_valid, 0);
        u_load(8'h60);
        chk("R7 miss load stalls", u_ld_ready, 0);
        chk("R7 no mem read while blocked", u_rd_en, 0);
        @(negedge clk); u_ld_addr = 8'h20; #1;
        chk("R5 R7 hit while blocked ready", u_ld_ready, 1);
        chk("R5 R7 hit while blocked data", u_ld_data, 16'h00B2);
        @(negedge clk); u_ld_valid = 0;
        @(negedge clk);
        chk("R7 nothing drained while blocked", log_n, 0);

        // R3 R8: release lock; four drains, fence done after the fourth
        lock = 0;
        begin
            int n;
            n = 0;
            #1;
            while (!u_fdone && n < 50) begin
                @(negedge clk); #1; n++;
            end
            chk("R8 fence done after four drains", n, 4);
        end
        u_fence = 0;
        chk("R2 R3 drain count, dropped store absent", log_n, 4);
        chk("R3 drain0 addr", log_a[0], 8'h10); chk("R3 drain0 data", log_d[0], 16'h00A1);
        chk("R3 drain1 addr", log_a[1], 8'h20); chk("R3 drain1 data", log_d[1], 16'h00B2);
        chk("R3 drain2 addr", log_a[2], 8'h10); chk("R3 drain2 data", log_d[2], 16'h00A3);
        chk("R3 drain3 addr", log_a[3], 8'h30); chk("R3 drain3 data", log_d[3], 16'h00C4);
        chk("R3 memory holds youngest", mem[8'h10], 16'h00A3);
        chk("R2 dropped store not in memory", mem[8'h50], 16'(8'h50 * 3));
        // R6 after drain: load now misses and reads memory
        u_load(8'h30);
        chk("R6 miss after drain fwd", u_fwd, 0);
        chk("R6 miss after drain data", u_ld_data, 16'h00C4);
        @(negedge clk); u_ld_valid = 0;

        // R4: drain request holds while memory not ready
        mem_ready = 0;
        u_store(8'h70, 16'h1234);
        #1;
        chk("R4 valid raised", u_wr_valid, 1);
        @(negedge clk); #1;
        chk("R4 valid held", u_wr_valid, 1);
        chk("R4 addr held", u_wr_addr, 8'h70);
        chk("R4 data held", u_wr_data, 16'h1234);
        mem_ready = 1;
        repeat (2) @(negedge clk);

        // R9: store-buffering outcome without fences
        mem[8'h40] = 0; mem[8'h41] = 0; mem_ready = 0;
        @(negedge clk);
        u_st_valid = 1; u_st_addr = 8'h40; u_st_data = 1;
        p_st_valid = 1; p_st_addr = 8'h41; p_st_data = 1;
        @(negedge clk);
        u_st_valid = 0; p_st_valid = 0;
        u_ld_valid = 1; u_ld_addr = 8'h41;
        p_ld_valid = 1; p_ld_addr = 8'h40; #1;
        chk("R9 no fence thread A reads 0", u_ld_data, 0);
        chk("R9 no fence thread B reads 0", p_ld_data, 0);
        @(negedge clk); u_ld_valid = 0; p_ld_valid = 0;
        mem_ready = 1;
        repeat (4) @(negedge clk);
        mem[8'h40] = 0; mem[8'h41] = 0;

        // R9: with fences the both-zero outcome disappears
        @(negedge clk);
        u_st_valid = 1; u_st_addr = 8'h40; u_st_data = 1;
        p_st_valid = 1; p_st_addr = 8'h41; p_st_data = 1;
        @(negedge clk);
        u_st_valid = 0; p_st_valid = 0;
        u_fence = 1; p_fence = 1;
        begin
            int n;
            n = 0;
            #1;
            while (!(u_fdone && p_fdone) && n < 50) begin
                @(negedge clk); #1; n++;
            end
            chk("R9 both fences complete", u_fdone && p_fdone, 1);
        end
        @(negedge clk);
        u_fence = 0; p_fence = 0;
        u_ld_valid = 1; u_ld_addr = 8'h41;
        p_ld_valid = 1; p_ld_addr = 8'h40; #1;
        chk("R9 fenced thread A reads 1", u_ld_data, 1);
        chk("R9 fenced thread B reads 1", p_ld_data, 1);
        @(negedge clk); u_ld_valid = 0; p_ld_valid = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule